// File: doc/BRIEF.md
# HDB3 Receive Decoder with Violation and Zero-Run Alarms

This block sits behind an E1-rate receive slicer and clock recovery. Each cycle of the recovered clock it takes one positive-rail pulse bit and one negative-rail pulse bit. In single-rail mode it merges the two rails into unipolar receive data. When line coding is enabled it also finds the zero-substitution patterns and restores the four zeros they stand for. It flags every same-polarity pulse pair that is not part of a legal substitution. In dual-rail mode the two rails pass through, with the same latency and no decoding.

The block watches the data it delivers for long runs of zeros and reports a digital loss of signal. While that alarm is active the data is forced low. If shutdown is enabled, the output clock is also parked at a fixed level. A receive alarm control replaces the data with all ones. An active-low alarm-test input forces the alarm outputs to their alarm state and leaves the data path alone. A polarity-select input makes the dual-rail outputs and the output clock active-low.

Top module: `hdb3_rx_decoder`

## Requirements
- R1: A pulse on either rail sampled at rising edge k is delivered as a 1 on `rx_d_p` from just after edge k+3 until edge k+4. A cycle with no pulse is delivered as a 0 in the same way. After reset every output bit is 0, `viol` is 0 and `los_n` is 1.
- R2: After reset the last pulse polarity is taken as negative. With coding disabled in single-rail mode, a pulse with the same polarity as the previous pulse sets `viol` for the single cycle that follows its sampling edge, and the pulse is still delivered as a 1. No zero pattern is removed in this mode.
- R3: With coding enabled, a pulse that repeats the previous polarity and follows three pulse-free cycles is delivered as 0 and does not set `viol`.
- R4: With coding enabled, a pulse that repeats the previous polarity and follows two pulse-free cycles, which in turn follow a pulse, is delivered as 0. The earlier pulse is also delivered as 0, and `viol` stays low.
- R5: With coding enabled, any other same-polarity pulse sets `viol` for one cycle and is delivered as 1.
- R6: `los_n` goes low after the 33rd consecutive 0 leaves the delay line, and returns high one edge after a pulse is delivered. While it is low the data outputs read as 0, including the cycle in which that pulse sits at the output.
- R7: While `ais_req` is 1, both data outputs carry ones, with the selected polarity applied. In single-rail mode `rx_d_p` is 1 and `rx_d_n` is 0.
- R8: While `alm_test_n` is 0, `viol` is 1 and `los_n` is 0, and the delivered data is unchanged.
- R9: In dual-rail mode the rails pass through with the R1 latency, without decoding, and `viol` stays 0. With `inv_mode` set, both rails and `clk_out` are inverted.
- R10: With `shutdown_en` set during loss of signal, `clk_out` is held at 1 and the data is held low. In dual-rail inverted mode `clk_out` is held at 0 and both rails at 1. Otherwise `clk_out` follows `rx_clk`, inverted only in dual-rail inverted mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rx_clk | input | 1 | Recovered receive clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_p | input | 1 | Positive-polarity pulse seen this cycle |
| line_n | input | 1 | Negative-polarity pulse seen this cycle |
| code_en | input | 1 | Enable zero-substitution decoding (single-rail only) |
| dual_rail | input | 1 | 1 selects two-rail output, 0 selects merged data |
| inv_mode | input | 1 | Active-low rails and inverted clock in dual-rail mode |
| ais_req | input | 1 | Replace receive data with all ones |
| alm_test_n | input | 1 | Active-low alarm test |
| shutdown_en | input | 1 | Park the clock and data during loss of signal |
| clk_out | output | 1 | Receive clock toward the terminal side |
| rx_d_p | output | 1 | Merged data, or positive rail |
| rx_d_n | output | 1 | Negative rail (0 in single-rail mode) |
| viol | output | 1 | Violation alarm, one cycle per event |
| los_n | output | 1 | Active-low digital loss-of-signal alarm |

## Verification
The hardest case to reach is the two-sided substitution. A legal pulse must sit exactly three cycles before a repeated-polarity pulse, and the alternation parity since the last substitution must call for it. The bench therefore runs its own line encoder over bit streams with injected zero runs of several lengths. This makes both substitution shapes appear with real polarity history. The forced-low data in R6 is also hard to reach, because it shows only in the single cycle when a pulse has reached the output and the zero counter has not yet cleared. A directed sequence times that pulse from the edge at which the alarm rose.

// File: rtl/hdb3_rx_pkg.sv
package hdb3_rx_pkg;

  typedef struct packed {
    logic p;
    logic n;
  } sym_t;

  typedef enum logic [1:0] {
    SUB_NONE = 2'd0,
    SUB_ZZZV = 2'd1,
    SUB_BZZV = 2'd2
  } sub_t;

  // A cycle carries a mark when either rail pulsed.
  function automatic logic sym_mark(sym_t s);
    return s.p | s.n;
  endfunction

  // Polarity of a mark: 1 = positive, 0 = negative.
  function automatic logic sym_pol(sym_t s);
    return s.p;
  endfunction

  // Shape of the three most recent cycles ahead of a repeated-polarity mark.
  // h[0] is the newest cycle.
  function automatic sub_t classify(logic [2:0] h);
    if (h == 3'b000) return SUB_ZZZV;
    if (h == 3'b100) return SUB_BZZV;
    return SUB_NONE;
  endfunction

endpackage

// File: rtl/rx_code_check.sv
module rx_code_check
  import hdb3_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  sym_t       in_sym,
  input  logic [2:0] hist_mark,
  input  logic       code_en,
  input  logic       dual_rail,
  output logic       sub_v,
  output logic       clr_b,
  output logic       viol_q
);

  logic last_pol;
  logic same_pol;
  logic hdb_on;
  logic viol_evt;
  sub_t kind;

  assign hdb_on   = code_en & ~dual_rail;
  assign same_pol = sym_mark(in_sym) & (sym_pol(in_sym) == last_pol);
  assign kind     = classify(hist_mark);
  assign sub_v    = hdb_on & same_pol & (kind != SUB_NONE);
  assign clr_b    = hdb_on & same_pol & (kind == SUB_BZZV);
  assign viol_evt = ~dual_rail & same_pol & ~sub_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pol <= 1'b0;
      viol_q   <= 1'b0;
    end else begin
      if (sym_mark(in_sym)) last_pol <= sym_pol(in_sym);
      viol_q <= viol_evt;
    end
  end

  AST_SUB_NOT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |-> !$past(sub_v)); // R3

endmodule

// File: rtl/rx_delay_line.sv
module rx_delay_line
  import hdb3_rx_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  sym_t       in_sym,
  input  logic       sub_v,
  input  logic       clr_b,
  output logic [2:0] hist_mark,
  output sym_t       out_sym
);

  localparam int CLR_STAGE = 3;

  sym_t st [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st[0] <= '0;
    else        st[0] <= sub_v ? sym_t'(2'b00) : in_sym;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    if (i == CLR_STAGE) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[i] <= '0;
        else        st[i] <= clr_b ? sym_t'(2'b00) : st[i-1];
      end
    end else begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st[i] <= '0;
        else        st[i] <= st[i-1];
      end
    end
  end

  assign hist_mark = {sym_mark(st[2]), sym_mark(st[1]), sym_mark(st[0])};
  assign out_sym   = st[DEPTH-1];

  AST_CLR_HITS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    clr_b |-> sym_mark(st[2])); // R4
  AST_V_REMOVED: assert property (@(posedge clk) disable iff (!rst_n)
    sub_v |=> !sym_mark(st[0])); // R3

endmodule

// File: rtl/rx_zero_watch.sv
module rx_zero_watch #(
  parameter int LIMIT = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mark_in,
  output logic los_act
);

  localparam int CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] CAP = CW'(LIMIT + 1);

  logic [CW-1:0] run_q;

  function automatic logic [CW-1:0] run_next(logic [CW-1:0] cur, logic mark);
    if (mark)       return '0;
    if (cur == CAP) return cur;
    return cur + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_next(run_q, mark_in);
  end

  assign los_act = (run_q == CAP);

  AST_LOS_AFTER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    los_act |-> !$past(mark_in)); // R6

endmodule

// File: rtl/hdb3_rx_decoder.sv
module hdb3_rx_decoder
  import hdb3_rx_pkg::*;
#(
  parameter int PIPE_DEPTH = 4,
  parameter int LOS_LIMIT  = 32
) (
  input  logic rx_clk,
  input  logic rst_n,
  input  logic line_p,
  input  logic line_n,
  input  logic code_en,
  input  logic dual_rail,
  input  logic inv_mode,
  input  logic ais_req,
  input  logic alm_test_n,
  input  logic shutdown_en,
  output logic clk_out,
  output logic rx_d_p,
  output logic rx_d_n,
  output logic viol,
  output logic los_n
);

  sym_t       in_sym;
  sym_t       out_sym;
  logic [2:0] hist_mark;
  logic       sub_v;
  logic       clr_b;
  logic       viol_q;
  logic       los_act;
  logic       rail_p;
  logic       rail_n;
  logic       park;
  logic       flip;

  assign in_sym.p = line_p;
  assign in_sym.n = line_n;

  rx_code_check u_check (
    .clk       (rx_clk),
    .rst_n     (rst_n),
    .in_sym    (in_sym),
    .hist_mark (hist_mark),
    .code_en   (code_en),
    .dual_rail (dual_rail),
    .sub_v     (sub_v),
    .clr_b     (clr_b),
    .viol_q    (viol_q)
  );

  rx_delay_line #(.DEPTH(PIPE_DEPTH)) u_delay (
    .clk       (rx_clk),
    .rst_n     (rst_n),
    .in_sym    (in_sym),
    .sub_v     (sub_v),
    .clr_b     (clr_b),
    .hist_mark (hist_mark),
    .out_sym   (out_sym)
  );

  rx_zero_watch #(.LIMIT(LOS_LIMIT)) u_zero (
    .clk     (rx_clk),
    .rst_n   (rst_n),
    .mark_in (sym_mark(out_sym)),
    .los_act (los_act)
  );

  always_comb begin
    if (ais_req) begin
      rail_p = 1'b1;
      rail_n = 1'b1;
    end else if (los_act) begin
      rail_p = 1'b0;
      rail_n = 1'b0;
    end else begin
      rail_p = out_sym.p;
      rail_n = out_sym.n;
    end
    if (dual_rail) begin
      rx_d_p = rail_p ^ inv_mode;
      rx_d_n = rail_n ^ inv_mode;
    end else begin
      rx_d_p = rail_p | rail_n;
      rx_d_n = 1'b0;
    end
  end

  assign flip    = dual_rail & inv_mode;
  assign park    = shutdown_en & los_act;
  assign clk_out = park ? ~flip : (rx_clk ^ flip);
  assign viol    = ~alm_test_n | (~dual_rail & viol_q);
  assign los_n   = alm_test_n & ~los_act;

  AST_DUAL_QUIET: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (dual_rail && alm_test_n) |-> !viol); // R9
  AST_TEST_ALARMS: assert property (@(posedge rx_clk) disable iff (!rst_n)
    !alm_test_n |-> (viol && !los_n)); // R8
  AST_AIS_SINGLE: assert property (@(posedge rx_clk) disable iff (!rst_n)
    (!dual_rail && ais_req) |-> (rx_d_p && !rx_d_n)); // R7

endmodule

// File: tb/hdb3_rx_decoder_tb.sv
module hdb3_rx_decoder_tb;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_p = 1'b0, line_n = 1'b0;
  logic code_en = 1'b0, dual_rail = 1'b0, inv_mode = 1'b0;
  logic ais_req = 1'b0, alm_test_n = 1'b1, shutdown_en = 1'b0;
  logic clk_out, rx_d_p, rx_d_n, viol, los_n;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit watch = 1'b0;
  int viol_seen = 0;
  bit done = 1'b0;

  typedef struct {
    int    due;
    logic  ep;
    logic  en;
    string tag;
  } item_t;
  item_t sb[$];

  hdb3_rx_decoder u_dut (
    .rx_clk(clk), .rst_n(rst_n), .line_p(line_p), .line_n(line_n),
    .code_en(code_en), .dual_rail(dual_rail), .inv_mode(inv_mode),
    .ais_req(ais_req), .alm_test_n(alm_test_n), .shutdown_en(shutdown_en),
    .clk_out(clk_out), .rx_d_p(rx_d_p), .rx_d_n(rx_d_n), .viol(viol), .los_n(los_n)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Monitor: compares delivered data against the scoreboard.
  always begin
    @(posedge clk);
    #5;
    if (watch && viol) viol_seen++;
    while (sb.size() > 0 && sb[0].due <= cyc) begin
      item_t it;
      it = sb.pop_front();
      chk(it.tag, "rx_d_p", int'(rx_d_p), int'(it.ep));
      chk(it.tag, "rx_d_n", int'(rx_d_n), int'(it.en));
    end
  end

  task automatic send(logic p, logic n, logic ep, logic en, string tag, output int c);
    item_t it;
    @(negedge clk);
    line_p = p;
    line_n = n;
    c = cyc + 1;
    it.due = c + 3; it.ep = ep; it.en = en; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    line_p = 1'b0;
    line_n = 1'b0;
  endtask

  task automatic wait_cyc(int n);
    while (cyc < n) begin
      @(posedge clk);
      #5;
    end
  endtask

  task automatic do_reset(logic ce, logic dr, logic im);
    idle();
    repeat (6) @(negedge clk);
    rst_n = 1'b0;
    code_en = ce; dual_rail = dr; inv_mode = im;
    ais_req = 1'b0; alm_test_n = 1'b1; shutdown_en = 1'b0;
    sb.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Bench-side line encoder: alternate marks, four zeros become 000V or B00V.
  task automatic run_stream(int n, int seed, string ovr);
    logic bits[$];
    logic lp = 1'b0;
    int ones = 0;
    int i = 0;
    int c;
    for (int k = 0; k < n; k++) begin
      int ph = k % 19;
      int zl = 4 + 3 * ((k / 19) % 4);
      bits.push_back((ph >= 2 && ph < 2 + zl) ? 1'b0 : logic'(((k * 7 + seed) % 3) != 0));
    end
    while (i < n) begin
      if (i + 3 < n && !bits[i] && !bits[i+1] && !bits[i+2] && !bits[i+3]) begin
        if (ones % 2 == 1) begin
          string t = (ovr != "") ? ovr : "R3";
          send(0, 0, 0, 0, t, c); send(0, 0, 0, 0, t, c); send(0, 0, 0, 0, t, c);
          send(lp, !lp, 0, 0, t, c);
        end else begin
          string t = (ovr != "") ? ovr : "R4";
          lp = !lp;
          send(lp, !lp, 0, 0, t, c); send(0, 0, 0, 0, t, c); send(0, 0, 0, 0, t, c);
          send(lp, !lp, 0, 0, t, c);
        end
        ones = 0;
        i += 4;
      end else if (bits[i]) begin
        lp = !lp;
        ones++;
        send(lp, !lp, 1, 0, (ovr != "") ? ovr : "R1", c);
        i++;
      end else begin
        send(0, 0, 0, 0, (ovr != "") ? ovr : "R1", c);
        i++;
      end
    end
    idle();
  endtask

  initial begin
    int c, c2;
    // Reset state (R1)
    do_reset(1'b0, 1'b0, 1'b0);
    wait_cyc(cyc + 2);
    chk("R1", "reset rx_d_p", rx_d_p, 0);
    chk("R1", "reset rx_d_n", rx_d_n, 0);
    chk("R1", "reset viol", viol, 0);
    chk("R1", "reset los_n", los_n, 1);

    // Coded stream with both substitution shapes (R3, R4)
    do_reset(1'b1, 1'b0, 1'b0);
    viol_seen = 0; watch = 1'b1;
    run_stream(150, 1, "");
    wait_cyc(cyc + 6);
    watch = 1'b0;
    chk("R3", "violations during legal codes", viol_seen, 0);

    // Bipolar violation, no substitution removal (R2)
    do_reset(1'b0, 1'b0, 1'b0);
    send(1, 0, 1, 0, "R2", c);
    send(1, 0, 1, 0, "R2", c);
    @(posedge clk); #5;
    chk("R2", "viol after repeated polarity", viol, 1);
    send(0, 1, 1, 0, "R2", c);
    @(posedge clk); #5;
    chk("R2", "viol one cycle only", viol, 0);
    send(0, 0, 0, 0, "R2", c); send(0, 0, 0, 0, "R2", c); send(0, 0, 0, 0, "R2", c);
    send(0, 1, 1, 0, "R2", c);
    @(posedge clk); #5;
    chk("R2", "viol on uncoded 000V", viol, 1);
    idle();
    wait_cyc(cyc + 6);

    // Illegal same-polarity pair with coding on (R5)
    do_reset(1'b1, 1'b0, 1'b0);
    send(1, 0, 1, 0, "R5", c);
    send(0, 0, 0, 0, "R5", c);
    send(1, 0, 1, 0, "R5", c);
    @(posedge clk); #5;
    chk("R5", "code violation flagged", viol, 1);
    idle();
    wait_cyc(cyc + 6);

    // Zero-run alarm and shutdown (R6, R10)
    do_reset(1'b0, 1'b0, 1'b0);
    send(1, 0, 1, 0, "R6", c);
    idle();
    wait_cyc(c + 36);
    chk("R6", "los_n after 32 zeros", los_n, 1);
    wait_cyc(c + 37);
    chk("R6", "los_n after 33 zeros", los_n, 0);
    @(negedge clk); shutdown_en = 1'b1; #3;
    chk("R10", "parked clk single", clk_out, 1);
    chk("R10", "parked data single", rx_d_p, 0);
    shutdown_en = 1'b0; #1;
    chk("R10", "clk follows when not parked", clk_out, 0);
    send(0, 1, 0, 0, "R6", c2);
    idle();
    wait_cyc(c2 + 3);
    chk("R6", "los_n still low with mark at output", los_n, 0);
    wait_cyc(c2 + 4);
    chk("R6", "los_n recovers after mark", los_n, 1);

    // Receive alarm signal, single rail (R7)
    @(negedge clk); ais_req = 1'b1;
    @(posedge clk); #5;
    chk("R7", "ais single rx_d_p", rx_d_p, 1);
    chk("R7", "ais single rx_d_n", rx_d_n, 0);
    @(negedge clk); ais_req = 1'b0;

    // Alarm test leaves data intact (R8)
    do_reset(1'b1, 1'b0, 1'b0);
    @(negedge clk); alm_test_n = 1'b0;
    @(posedge clk); #5;
    chk("R8", "forced viol", viol, 1);
    chk("R8", "forced los_n", los_n, 0);
    run_stream(60, 2, "R8");
    wait_cyc(cyc + 6);
    alm_test_n = 1'b1;

    // Dual rail pass-through (R9)
    do_reset(1'b1, 1'b1, 1'b0);
    viol_seen = 0; watch = 1'b1;
    send(1, 0, 1, 0, "R9", c);
    send(1, 0, 1, 0, "R9", c);
    send(0, 1, 0, 1, "R9", c);
    send(0, 0, 0, 0, "R9", c); send(0, 0, 0, 0, "R9", c);
    send(0, 0, 0, 0, "R9", c); send(0, 0, 0, 0, "R9", c);
    send(0, 1, 0, 1, "R9", c);
    idle();
    wait_cyc(cyc + 6);
    watch = 1'b0;
    chk("R9", "no viol in dual rail", viol_seen, 0);
    @(negedge clk); ais_req = 1'b1;
    @(posedge clk); #5;
    chk("R7", "ais dual p", rx_d_p, 1);
    chk("R7", "ais dual n", rx_d_n, 1);
    @(negedge clk); ais_req = 1'b0;

    // Dual rail, inverted polarity (R9, R7, R10)
    do_reset(1'b0, 1'b1, 1'b1);
    send(1, 0, 0, 1, "R9", c);
    send(0, 1, 1, 0, "R9", c);
    send(0, 0, 1, 1, "R9", c);
    idle();
    wait_cyc(cyc + 6);
    @(negedge clk); #3;
    chk("R9", "inverted clk low phase", clk_out, 1);
    ais_req = 1'b1;
    @(posedge clk); #5;
    chk("R7", "ais inverted p", rx_d_p, 0);
    chk("R7", "ais inverted n", rx_d_n, 0);
    @(negedge clk); ais_req = 1'b0; shutdown_en = 1'b1;
    wait_cyc(cyc + 40);
    @(negedge clk); #3;
    chk("R10", "parked clk inverted", clk_out, 0);
    chk("R10", "parked p inverted", rx_d_p, 1);
    chk("R10", "parked n inverted", rx_d_n, 1);
    inv_mode = 1'b0; #1;
    chk("R10", "parked clk dual normal", clk_out, 1);
    chk("R10", "parked rails dual normal", int'({rx_d_p, rx_d_n}), 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule